// File: doc/BRIEF.md
# Packed Lane Multiply-Accumulate Unit

This block is a datapath slice for a packed-integer execution pipe. It takes two 64-bit operands, treats each as four 16-bit lanes, and drives them through one shared array of four lane multipliers. A 3-bit opcode then picks how the four 32-bit lane products are reduced: kept per lane as their low or high halves, summed in adjacent pairs into two 32-bit fields, summed across all four lanes into one 64-bit value, or added into a 64-bit accumulator value supplied on a separate input.

A one-cycle strobe `in_valid` captures a result. The result register updates only on a strobe. `out_valid` rises in the following cycle. A sign select decides whether the lanes are sign-extended or zero-extended before they are multiplied. The three accumulate opcodes always treat their sources as signed. They read only the low 32 bits of each operand.

Top module: `pmac_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is 0. `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise.
- R2: When `in_valid` is low, `result` keeps its previous value whatever the other inputs do.
- R3: Opcode 0 (multiply, keep low): for each lane i, result bits [16i+15:16i] are bits [15:0] of the product of lane i of `src_a` and lane i of `src_b`.
- R4: Opcode 1 (multiply, keep high): for each lane i, result bits [16i+15:16i] are bits [31:16] of the lane product. With `is_signed`=1 the lanes are sign-extended before the multiply, for example 0x8000*0x8000 gives 0x4000. With `is_signed`=0 they are zero-extended, for example 0xFFFF*0xFFFF gives 0xFFFE.
- R5: Opcode 2 (pair sum): bits [31:0] hold lane0 product plus lane1 product, and bits [63:32] hold lane2 product plus lane3 product. Each sum is truncated to 32 bits.
- R6: Opcode 3 (quad sum): the result is the sum of all four lane products as a 64-bit value. The products are sign-extended when `is_signed`=1 and zero-extended when it is 0, so in unsigned mode bits [63:34] are always 0.
- R7: Opcode 4 (accumulate halfwords): the result is `acc_in` plus the signed product of bits [15:0] of the two sources plus the signed product of bits [31:16] of the two sources. Each product is sign-extended to 64 bits, and `is_signed` has no effect.
- R8: Opcode 5 (accumulate word): the result is `acc_in` plus the signed 64-bit product of `src_a[31:0]` and `src_b[31:0]`. `is_signed` has no effect.
- R9: Opcode 6 (accumulate low halfword): the result is `acc_in` plus the sign-extended signed product of `src_a[15:0]` and `src_b[15:0]`. `is_signed` has no effect.
- R10: Opcode 7 is reserved and captures a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; captures a result |
| opcode | input | 3 | Reduction select, encoded as 0..7 per R3 to R10 |
| is_signed | input | 1 | 1 = sign-extend lanes, 0 = zero-extend (opcodes 0 to 3) |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| acc_in | input | 64 | Accumulator value for opcodes 4 to 6 |
| out_valid | output | 1 | High the cycle after a strobe |
| result | output | 64 | Registered result |

## Verification
Some behaviours are checked by assertions on every cycle:
- the valid timing and the result hold;
- the zero result for the reserved opcode;
- the zero upper bits of an unsigned quad sum;
- a word accumulate with a zero source returning the accumulator unchanged.

The arithmetic of each reduction shape can only be shown by the bench's scenarios, which compare the result with an independent model under random and directed operands. These scenarios cover:
- the signed and unsigned extension extremes;
- pair-sum truncation;
- negative quad sums;
- accumulate opcodes issued with `is_signed` low.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL_LO   = 3'd0,
    OP_MUL_HI   = 3'd1,
    OP_PAIR_SUM = 3'd2,
    OP_QUAD_SUM = 3'd3,
    OP_ACC_HALF = 3'd4,
    OP_ACC_WORD = 3'd5,
    OP_ACC_LOW  = 3'd6,
    OP_RSVD     = 3'd7
  } pmac_op_e;
endpackage

// File: rtl/pmac_lane_mul.sv
// Array of lane multipliers; each lane is extended by one bit so that a
// single signed multiplier serves both signed and unsigned operands.
module pmac_lane_mul #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic                    sign_mode,
  input  logic [DATA_W-1:0]       op_a,
  input  logic [DATA_W-1:0]       op_b,
  output logic [LANES*PROD_W-1:0] prods
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [LANE_W:0]   ext_a;
    logic signed [LANE_W:0]   ext_b;
    logic signed [PROD_W+1:0] full_p;

    always_comb begin
      ext_a  = {sign_mode & op_a[g*LANE_W+LANE_W-1], op_a[g*LANE_W +: LANE_W]};
      ext_b  = {sign_mode & op_b[g*LANE_W+LANE_W-1], op_b[g*LANE_W +: LANE_W]};
      full_p = (PROD_W+2)'(ext_a) * (PROD_W+2)'(ext_b);
    end

    assign prods[g*PROD_W +: PROD_W] = full_p[PROD_W-1:0];
  end
endmodule

// File: rtl/pmac_reduce.sv
// Selects the reduction shape applied to the lane products.
module pmac_reduce
  import pmac_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W,
  localparam int PAIRS  = LANES / 2
) (
  input  pmac_op_e                op_sel,
  input  logic                    sign_mode,
  input  logic [LANES*PROD_W-1:0] prods,
  input  logic [PROD_W-1:0]       word_a,
  input  logic [PROD_W-1:0]       word_b,
  input  logic [DATA_W-1:0]       acc,
  output logic [DATA_W-1:0]       red_out
);
  logic [PROD_W-1:0] lane_p [LANES];
  logic [DATA_W-1:0] lane_x [LANES];
  logic [DATA_W-1:0] quad_sum;
  logic [DATA_W-1:0] word_prod;

  for (genvar g = 0; g < LANES; g++) begin : g_ext
    assign lane_p[g] = prods[g*PROD_W +: PROD_W];
    assign lane_x[g] = {{(DATA_W-PROD_W){sign_mode & lane_p[g][PROD_W-1]}}, lane_p[g]};
  end

  always_comb begin
    quad_sum = '0;
    for (int i = 0; i < LANES; i++) quad_sum = quad_sum + lane_x[i];
  end

  always_comb begin
    word_prod = {{(DATA_W-PROD_W){word_a[PROD_W-1]}}, word_a} *
                {{(DATA_W-PROD_W){word_b[PROD_W-1]}}, word_b};
  end

  always_comb begin
    red_out = '0;
    unique case (op_sel)
      OP_MUL_LO:
        for (int i = 0; i < LANES; i++) red_out[i*LANE_W +: LANE_W] = lane_p[i][LANE_W-1:0];
      OP_MUL_HI:
        for (int i = 0; i < LANES; i++) red_out[i*LANE_W +: LANE_W] = lane_p[i][PROD_W-1:LANE_W];
      OP_PAIR_SUM:
        for (int j = 0; j < PAIRS; j++) red_out[j*PROD_W +: PROD_W] = lane_p[2*j] + lane_p[2*j+1];
      OP_QUAD_SUM: red_out = quad_sum;
      OP_ACC_HALF: red_out = acc + lane_x[0] + lane_x[1];
      OP_ACC_WORD: red_out = acc + word_prod;
      OP_ACC_LOW:  red_out = acc + lane_x[0];
      default:     red_out = '0;
    endcase
  end
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
  import pmac_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W,
  localparam int GROW_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        opcode,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  pmac_op_e                op_sel;
  logic                    acc_op;
  logic                    eff_sign;
  logic [LANES*PROD_W-1:0] prods;
  logic [DATA_W-1:0]       red_out;

  logic [DATA_W-1:0] result_q, result_d;
  logic              vld_q, vld_d;

  assign op_sel   = pmac_op_e'(opcode);
  assign acc_op   = (op_sel == OP_ACC_HALF) || (op_sel == OP_ACC_WORD) || (op_sel == OP_ACC_LOW);
  assign eff_sign = is_signed | acc_op;

  pmac_lane_mul #(.LANE_W(LANE_W), .LANES(LANES)) mul_i (
    .sign_mode (eff_sign),
    .op_a      (src_a),
    .op_b      (src_b),
    .prods     (prods)
  );

  pmac_reduce #(.LANE_W(LANE_W), .LANES(LANES)) red_i (
    .op_sel    (op_sel),
    .sign_mode (eff_sign),
    .prods     (prods),
    .word_a    (src_a[PROD_W-1:0]),
    .word_b    (src_b[PROD_W-1:0]),
    .acc       (acc_in),
    .red_out   (red_out)
  );

  always_comb begin
    vld_d    = in_valid;
    result_d = in_valid ? red_out : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      result_q <= '0;
    end else begin
      vld_q    <= vld_d;
      result_q <= result_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = result_q;

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'(OP_RSVD)) |=> result == '0);
  // R6
  quad_unsigned_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'(OP_QUAD_SUM) && !is_signed) |=> result[DATA_W-1:PROD_W+GROW_W] == '0);
  // R8
  acc_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'(OP_ACC_WORD) && src_a[PROD_W-1:0] == '0) |=> result == $past(acc_in));
endmodule

// File: tb/pmac_unit_tb_top.sv
`timescale 1ns/1ps
module pmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  opcode;
  logic        is_signed;
  logic [63:0] src_a, src_b, acc_in;
  logic        out_valid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pmac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .is_signed(is_signed), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint lane_val(logic [63:0] v, int i, logic sg);
    logic [15:0] h;
    h = v[16*i +: 16];
    return sg ? longint'($signed(h)) : longint'({48'd0, h});
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic sg, logic [63:0] a,
                                        logic [63:0] b, logic [63:0] c);
    longint p [4];
    longint s;
    logic [63:0] r;
    logic [31:0] t;
    r = '0;
    for (int i = 0; i < 4; i++) p[i] = lane_val(a, i, sg) * lane_val(b, i, sg);
    case (op)
      3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
      3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
      3'd2: begin
        t = p[0][31:0] + p[1][31:0]; r[31:0] = t;
        t = p[2][31:0] + p[3][31:0]; r[63:32] = t;
      end
      3'd3: begin s = p[0] + p[1] + p[2] + p[3]; r = s; end
      3'd4: r = c + 64'(lane_val(a, 0, 1'b1) * lane_val(b, 0, 1'b1))
                  + 64'(lane_val(a, 1, 1'b1) * lane_val(b, 1, 1'b1));
      3'd5: r = c + 64'(longint'($signed(a[31:0])) * longint'($signed(b[31:0])));
      3'd6: r = c + 64'(lane_val(a, 0, 1'b1) * lane_val(b, 0, 1'b1));
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [2:0] op, logic sg, logic [63:0] a,
                        logic [63:0] b, logic [63:0] c, bit hold_chk);
    logic [63:0] exp;
    exp = model(op, sg, a, b, c);
    opcode = op; is_signed = sg; src_a = a; src_b = b; acc_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {63'd0, out_valid}, 64'd1);
    check(req, result, exp);
    if (hold_chk) begin
      // R2: inputs change without a strobe; result must not move
      opcode = 3'($urandom); is_signed = 1'($urandom);
      src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R2", result, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; is_signed = 1'b0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op("R4", 3'd1, 1'b1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, 1);
    check("R4", result, 64'h4000_4000_4000_4000);
    run_op("R4", 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    check("R4", result, 64'hFFFE_FFFE_FFFE_FFFE);
    run_op("R3", 3'd0, 1'b0, 64'hFFFF_0003_0100_1234, 64'hFFFF_0005_0100_0002, 0, 1);
    check("R3", result, 64'h0001_000F_0000_2468);
    run_op("R5", 3'd2, 1'b1, 64'h0001_0001_8000_8000, 64'h0002_0003_8000_8000, 0, 1);
    check("R5", result, 64'h0000_0005_8000_0000);
    run_op("R6", 3'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 1);
    check("R6", result, 64'hFFFF_FFFF_FFFF_FFFC);
    run_op("R6", 3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    check("R6", result, 64'h0000_0003_FFF8_0004);
    run_op("R7", 3'd4, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0002_0003, 64'd10, 1);
    check("R7", result, 64'd5);
    run_op("R8", 3'd5, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0007, 64'd3, 1);
    check("R8", result, 64'hFFFF_FFFF_FFFF_FFFC);
    run_op("R9", 3'd6, 1'b0, 64'h0000_0000_0005_FFFE, 64'h0000_0000_0009_0004, 64'd0, 1);
    check("R9", result, 64'hFFFF_FFFF_FFFF_FFF8);
    run_op("R10", 3'd7, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 64'd99, 1);

    // constrained random, every opcode and sign mode
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      case (op)
        3'd0: run_op("R3", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd1: run_op("R4", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd2: run_op("R5", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd3: run_op("R6", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd4: run_op("R7", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd5: run_op("R8", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        3'd6: run_op("R9", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
        default: run_op("R10", op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n % 4 == 0);
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule